// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits between a 32-bit register bus and a behavioural model of a one-time-programmable fuse array of 64 words of 32 bits. Bits in the array can be burned from 0 to 1 and never return to 0. Software starts one of three operations by writing a command code to the control register. A sense operation copies the whole array into a sensed view. A read operation returns one word of that sensed view. A program operation burns the write-data pattern into one word. Even and odd word addresses form a primary/mirror pair, and software burns both words of a pair itself.

Software polls a state field in the control register until it reports idle. A program operation needs the power-good bit to be set. It lasts for the number of clock cycles held in the pulse-time register. At 250 MHz the reset value of 2500 cycles gives a 10 us pulse, inside the allowed 9 to 11 us window. A sticky lock register blocks every program request until reset. A load strobe streams the sensed words, one per cycle, onto an options output and raises a done flag. A separate visibility register hides all the other registers until software opens them.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the visibility bit, the lock, power-good and the error and done flags are 0. The pulse-time register (offset 0x1C) holds 2500, and the state field (control bits [19:16]) reads 4, meaning idle.
- R2: While bit 28 of the visibility register (offset 0x48) is 0, reads of every other offset return 0 and writes to them have no effect. Offset 0x48 itself is always readable and writable.
- R3: Writing control (0x00) with bits [1:0] = 1 starts a read and = 3 starts a sense. Each stays busy for exactly 4 cycles. While busy the state field shows the command code (1 read, 2 program, 3 sense, 5 load).
- R4: A program command (code 2) stays busy for the pulse-time register's count of cycles (at least 1). It then ORs the write-data register (0x0C) into the word chosen by the address register (0x04). No bit is ever cleared.
- R5: A program command is rejected when power-good (bit 0 of 0x34) is 0 or the lock is set. A rejected command sets the error flag (control bit 8), leaves the state idle and leaves the array unchanged. The next accepted command clears the flag.
- R6: Writing 1 to bit 0 of the lock register (0x2C) sets a lock that writing 0 does not clear. Only reset clears it.
- R7: A read command loads the read-data register (0x08) with the addressed word as captured by the most recent sense. A burn does not show until a later sense.
- R8: The two words of an even/odd pair are independent. Programming one of them leaves its partner unchanged.
- R9: Writing bit 0 = 1 to the load register (0x20) while idle clears the done flag (control bit 30). The block then presents sensed words 0 to 63 on the options port, one per cycle with the index counting up. After the last word the done flag is set.
- R10: Command or load writes made while an operation is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| opt_valid | output | 1 | Options word valid during a load |
| opt_index | output | 6 | Index of the options word |
| opt_word | output | 32 | Sensed fuse word being loaded |

## Verification
The assertions assume a bus that presents at most one register write per cycle and keeps its inputs stable across each rising edge. The bench drives every input one nanosecond after a rising edge and samples half a period later, so each write lands on exactly one edge. The assertions also treat reset as the only event that may clear fuse bits or the lock. The bench asserts reset a second time only once the lock and the load behaviour have been checked. Commands are issued both while idle and while busy, so the ignore rule is exercised, but never two in the same cycle.

// File: rtl/otp_pkg.sv
package otp_pkg;
    // register byte offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_ADDR  = 8'h04;
    localparam logic [7:0] OFS_RDAT  = 8'h08;
    localparam logic [7:0] OFS_WDAT  = 8'h0C;
    localparam logic [7:0] OFS_PTIME = 8'h1C;
    localparam logic [7:0] OFS_LOAD  = 8'h20;
    localparam logic [7:0] OFS_LOCK  = 8'h2C;
    localparam logic [7:0] OFS_PWR   = 8'h34;
    localparam logic [7:0] OFS_VIS   = 8'h48;

    // bit positions in the register words
    localparam int VIS_BIT  = 28;
    localparam int DONE_BIT = 30;
    localparam int ERR_BIT  = 8;
    localparam int ST_LSB   = 16;

    // command codes in control bits [1:0]
    localparam logic [1:0] CMD_NONE  = 2'd0;
    localparam logic [1:0] CMD_READ  = 2'd1;
    localparam logic [1:0] CMD_BURN  = 2'd2;
    localparam logic [1:0] CMD_SENSE = 2'd3;

    typedef enum logic [3:0] {
        ST_READ  = 4'd1,
        ST_BURN  = 4'd2,
        ST_SENSE = 4'd3,
        ST_IDLE  = 4'd4,
        ST_LOAD  = 4'd5
    } seq_state_e;
endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
    parameter int NUM_WORDS = 64,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          burn_en,
    input  logic [IDX_W-1:0]              burn_idx,
    input  logic [DATA_W-1:0]             burn_val,
    input  logic                          sense_en,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [DATA_W-1:0]             rd_word,
    input  logic [IDX_W-1:0]              opt_idx,
    output logic [DATA_W-1:0]             opt_word,
    output logic [NUM_WORDS*DATA_W-1:0]   fuse_flat
);
    logic [DATA_W-1:0] sensed_w [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        typedef struct packed {
            logic [DATA_W-1:0] raw;   // burned state of the fuses
            logic [DATA_W-1:0] shd;   // value captured by the last sense
        } cell_t;

        cell_t cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (burn_en && (burn_idx == IDX_W'(w))) begin
                cell_d.raw = cell_q.raw | burn_val;
            end
            if (sense_en) begin
                cell_d.shd = cell_q.raw;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else begin
                cell_q <= cell_d;
            end
        end

        assign sensed_w[w]                    = cell_q.shd;
        assign fuse_flat[w*DATA_W +: DATA_W] = cell_q.raw;
    end

    assign rd_word  = sensed_w[rd_idx];
    assign opt_word = sensed_w[opt_idx];
endmodule

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
#(
    parameter int NUM_WORDS = 64,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 6,
    parameter int TIME_W    = 16,
    parameter int STEP_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic [1:0]        cmd,
    input  logic              load_go,
    input  logic              pwr_ok,
    input  logic              prog_lock,
    input  logic [TIME_W-1:0] pulse_cyc,
    input  logic [IDX_W-1:0]  op_idx_in,
    input  logic [DATA_W-1:0] op_val_in,
    output logic [3:0]        state_code,
    output logic              burn_en,
    output logic [IDX_W-1:0]  burn_idx,
    output logic [DATA_W-1:0] burn_val,
    output logic              sense_en,
    output logic              rd_done,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              prog_reject,
    output logic              err,
    output logic              done,
    output logic              opt_valid,
    output logic [IDX_W-1:0]  opt_index
);
    localparam logic [TIME_W-1:0] STEP_LAST = TIME_W'(STEP_CYC - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [TIME_W-1:0] cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] val;
        logic [IDX_W-1:0]  oidx;
        logic              err;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;
    logic busy;
    logic [TIME_W-1:0] burn_last;

    always_comb begin
        s_d         = s_q;
        burn_en     = 1'b0;
        sense_en    = 1'b0;
        rd_done     = 1'b0;
        prog_reject = 1'b0;
        busy        = (s_q.st != ST_IDLE);
        burn_last   = (pulse_cyc == '0) ? '0 : pulse_cyc - 1'b1;

        // advance the running operation
        unique case (s_q.st)
            ST_READ, ST_SENSE, ST_BURN: begin
                if (s_q.cnt == '0) begin
                    s_d.st   = ST_IDLE;
                    burn_en  = (s_q.st == ST_BURN);
                    sense_en = (s_q.st == ST_SENSE);
                    rd_done  = (s_q.st == ST_READ);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_LOAD: begin
                if (s_q.oidx == LAST_IDX) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.oidx = s_q.oidx + 1'b1;
                end
            end
            default: ;
        endcase

        // accept a new request only while idle
        if (!busy) begin
            if (cmd_go && (cmd != CMD_NONE)) begin
                if ((cmd == CMD_BURN) && (!pwr_ok || prog_lock)) begin
                    s_d.err     = 1'b1;
                    prog_reject = 1'b1;
                end else begin
                    s_d.err = 1'b0;
                    s_d.idx = op_idx_in;
                    s_d.val = op_val_in;
                    unique case (cmd)
                        CMD_READ: begin
                            s_d.st  = ST_READ;
                            s_d.cnt = STEP_LAST;
                        end
                        CMD_BURN: begin
                            s_d.st  = ST_BURN;
                            s_d.cnt = burn_last;
                        end
                        default: begin
                            s_d.st  = ST_SENSE;
                            s_d.cnt = STEP_LAST;
                        end
                    endcase
                end
            end else if (load_go) begin
                s_d.st   = ST_LOAD;
                s_d.oidx = '0;
                s_d.done = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign state_code = s_q.st;
    assign burn_idx   = s_q.idx;
    assign burn_val   = s_q.val;
    assign rd_idx     = s_q.idx;
    assign err        = s_q.err;
    assign done       = s_q.done;
    assign opt_valid  = (s_q.st == ST_LOAD);
    assign opt_index  = s_q.oidx;
endmodule

// File: rtl/otp_regs.sv
module otp_regs
    import otp_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 6,
    parameter int TIME_W    = 16,
    parameter int PTIME_RST = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [3:0]        state_code,
    input  logic              err,
    input  logic              done,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_word,
    output logic              cmd_go,
    output logic [1:0]        cmd,
    output logic              load_go,
    output logic              pwr_ok,
    output logic              prog_lock,
    output logic [TIME_W-1:0] pulse_cyc,
    output logic [IDX_W-1:0]  op_idx,
    output logic [DATA_W-1:0] op_val
);
    typedef struct packed {
        logic              vis;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdat;
        logic [TIME_W-1:0] ptime;
        logic              lock;
        logic              pwr;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit;

    always_comb begin
        r_d     = r_q;
        hit     = reg_we && r_q.vis;
        cmd_go  = hit && (reg_addr == OFS_CTRL);
        cmd     = reg_wdata[1:0];
        load_go = hit && (reg_addr == OFS_LOAD) && reg_wdata[0];

        if (rd_done) begin
            r_d.rdat = rd_word;
        end
        if (reg_we && (reg_addr == OFS_VIS)) begin
            r_d.vis = reg_wdata[VIS_BIT];
        end
        if (hit) begin
            unique case (reg_addr)
                OFS_ADDR:  r_d.idx   = reg_wdata[IDX_W-1:0];
                OFS_WDAT:  r_d.wdat  = reg_wdata;
                OFS_PTIME: r_d.ptime = reg_wdata[TIME_W-1:0];
                OFS_LOCK:  r_d.lock  = r_q.lock | reg_wdata[0];
                OFS_PWR:   r_d.pwr   = reg_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_VIS) begin
            reg_rdata[VIS_BIT] = r_q.vis;
        end else if (r_q.vis) begin
            unique case (reg_addr)
                OFS_CTRL: begin
                    reg_rdata[ST_LSB +: 4] = state_code;
                    reg_rdata[ERR_BIT]     = err;
                    reg_rdata[DONE_BIT]    = done;
                end
                OFS_ADDR:  reg_rdata = DATA_W'(r_q.idx);
                OFS_RDAT:  reg_rdata = r_q.rdat;
                OFS_WDAT:  reg_rdata = r_q.wdat;
                OFS_PTIME: reg_rdata = DATA_W'(r_q.ptime);
                OFS_LOCK:  reg_rdata = DATA_W'(r_q.lock);
                OFS_PWR:   reg_rdata = DATA_W'(r_q.pwr);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.ptime <= TIME_W'(PTIME_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign pwr_ok    = r_q.pwr;
    assign prog_lock = r_q.lock;
    assign pulse_cyc = r_q.ptime;
    assign op_idx    = r_q.idx;
    assign op_val    = r_q.wdat;
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
    parameter int NUM_WORDS = 64,
    parameter int DATA_W    = 32,
    parameter int TIME_W    = 16,
    parameter int STEP_CYC  = 4,
    parameter int PTIME_RST = 2500,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              opt_valid,
    output logic [IDX_W-1:0]  opt_index,
    output logic [DATA_W-1:0] opt_word
);
    logic                        cmd_go, load_go, pwr_ok, prog_lock;
    logic [1:0]                  cmd;
    logic [TIME_W-1:0]           pulse_cyc;
    logic [IDX_W-1:0]            op_idx, burn_idx, rd_idx;
    logic [DATA_W-1:0]           op_val, burn_val, rd_word;
    logic [3:0]                  st_code;
    logic                        burn_en, sense_en, rd_done;
    logic                        prog_reject, seq_err, load_done;
    logic [NUM_WORDS*DATA_W-1:0] fuse_flat;

    otp_regs #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .TIME_W(TIME_W), .PTIME_RST(PTIME_RST)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .state_code(st_code), .err(seq_err), .done(load_done),
        .rd_done(rd_done), .rd_word(rd_word),
        .cmd_go(cmd_go), .cmd(cmd), .load_go(load_go),
        .pwr_ok(pwr_ok), .prog_lock(prog_lock), .pulse_cyc(pulse_cyc),
        .op_idx(op_idx), .op_val(op_val)
    );

    otp_seq #(
        .NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .TIME_W(TIME_W), .STEP_CYC(STEP_CYC)
    ) i_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_go(cmd_go), .cmd(cmd), .load_go(load_go),
        .pwr_ok(pwr_ok), .prog_lock(prog_lock), .pulse_cyc(pulse_cyc),
        .op_idx_in(op_idx), .op_val_in(op_val),
        .state_code(st_code),
        .burn_en(burn_en), .burn_idx(burn_idx), .burn_val(burn_val),
        .sense_en(sense_en), .rd_done(rd_done), .rd_idx(rd_idx),
        .prog_reject(prog_reject), .err(seq_err), .done(load_done),
        .opt_valid(opt_valid), .opt_index(opt_index)
    );

    otp_fuse_array #(
        .NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) i_array (
        .clk(clk), .rst_n(rst_n),
        .burn_en(burn_en), .burn_idx(burn_idx), .burn_val(burn_val),
        .sense_en(sense_en),
        .rd_idx(rd_idx), .rd_word(rd_word),
        .opt_idx(opt_index), .opt_word(opt_word),
        .fuse_flat(fuse_flat)
    );
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
    parameter int NUM_WORDS = 64,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [3:0]                  st,
    input logic [NUM_WORDS*DATA_W-1:0] fuse_flat,
    input logic                        prog_reject,
    input logic                        prog_lock,
    input logic                        opt_valid,
    input logic [IDX_W-1:0]            opt_index,
    input logic                        done
);
    // R3: the state field only ever takes a defined code
    a_r3_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (st >= 4'd1) && (st <= 4'd5));

    // R4: a fuse bit that is set stays set
    a_r4_fuse_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fuse_flat & $past(fuse_flat)) == $past(fuse_flat)));

    // R5: a rejected program leaves the sequencer idle and the array untouched
    a_r5_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        prog_reject |=> ((st == 4'd4) && $stable(fuse_flat)));

    // R6: the lock holds until reset
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        prog_lock |=> prog_lock);

    // R9: options indices advance by one during a load
    a_r9_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        opt_valid |=> (!opt_valid || (opt_index == $past(opt_index) + 1'b1)));

    // R9: done is raised when a load stream ends
    a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(opt_valid) |-> done);
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(
    .NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .st(st_code), .fuse_flat(fuse_flat),
    .prog_reject(prog_reject), .prog_lock(prog_lock),
    .opt_valid(opt_valid), .opt_index(opt_index), .done(load_done)
);

// File: tb/test_otp_fuse_ctrl.sv
`timescale 1ns/1ps
module test_otp_fuse_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        opt_valid;
    logic [5:0]  opt_index;
    logic [31:0] opt_word;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    otp_fuse_ctrl i_otp_fuse_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .opt_valid(opt_valid), .opt_index(opt_index), .opt_word(opt_word)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic        m_vis, m_lock, m_pwr, m_err, m_done, m_busy0;
    logic [5:0]  m_addr;
    logic [31:0] m_wdat, m_rdat, m_val;
    int          m_pt, m_st, m_cnt, m_idx, m_oi;
    logic [31:0] m_arr  [64];
    logic [31:0] m_sens [64];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_vis = 0; m_lock = 0; m_pwr = 0; m_err = 0; m_done = 0;
            m_addr = 0; m_wdat = 0; m_rdat = 0; m_val = 0;
            m_pt = 2500; m_st = 4; m_cnt = 0; m_idx = 0; m_oi = 0;
            foreach (m_arr[i]) begin m_arr[i] = 0; m_sens[i] = 0; end
        end else begin
            m_busy0 = (m_st != 4);
            if (m_st >= 1 && m_st <= 3) begin
                if (m_cnt == 0) begin
                    if (m_st == 1) m_rdat = m_sens[m_idx];
                    else if (m_st == 2) m_arr[m_idx] = m_arr[m_idx] | m_val;
                    else foreach (m_sens[i]) m_sens[i] = m_arr[i];
                    m_st = 4;
                end else m_cnt--;
            end else if (m_st == 5) begin
                if (m_oi == 63) begin m_st = 4; m_done = 1; end
                else m_oi++;
            end
            if (reg_we) begin
                if (reg_addr == 8'h48) m_vis = reg_wdata[28];
                else if (m_vis) begin
                    case (reg_addr)
                        8'h00: if (!m_busy0 && reg_wdata[1:0] != 0) begin
                            if (reg_wdata[1:0] == 2 && (!m_pwr || m_lock)) m_err = 1;
                            else begin
                                m_err = 0; m_st = int'(reg_wdata[1:0]);
                                m_cnt = (reg_wdata[1:0] == 2) ? ((m_pt == 0) ? 0 : m_pt - 1) : 3;
                                m_idx = int'(m_addr); m_val = m_wdat;
                            end
                        end
                        8'h04: m_addr = reg_wdata[5:0];
                        8'h0C: m_wdat = reg_wdata;
                        8'h1C: m_pt = int'(reg_wdata[15:0]);
                        8'h20: if (!m_busy0 && reg_wdata[0]) begin m_st = 5; m_oi = 0; m_done = 0; end
                        8'h2C: if (reg_wdata[0]) m_lock = 1;
                        8'h34: m_pwr = reg_wdata[0];
                        default: ;
                    endcase
                end
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] v = '0;
        if (a == 8'h48) v[28] = m_vis;
        else if (m_vis) begin
            case (a)
                8'h00: begin v[19:16] = 4'(m_st); v[8] = m_err; v[30] = m_done; end
                8'h04: v = 32'(m_addr);
                8'h08: v = m_rdat;
                8'h0C: v = m_wdat;
                8'h1C: v = 32'(m_pt);
                8'h2C: v = 32'(m_lock);
                8'h34: v = 32'(m_pwr);
                default: ;
            endcase
        end
        return v;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 R3 register view vs model", 64'(reg_rdata), 64'(m_read(reg_addr)));
            chk("R9 options port vs model", {25'd0, opt_valid, opt_index, opt_word},
                {25'd0, (m_st == 5), 6'(m_oi), m_sens[m_oi]});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1; reg_addr = a;
        @(negedge clk); d = reg_rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        reg_addr = 8'h00;
        forever begin
            @(negedge clk);
            if (reg_rdata[19:16] != 4'd4) n++;
            else break;
        end
    endtask

    task automatic do_read(input int idx, output int n, output logic [31:0] d);
        wr(8'h04, 32'(idx));
        wr(8'h00, 32'd1);
        wait_idle(n);
        rd(8'h08, d);
    endtask

    task automatic do_sense(output int n);
        wr(8'h00, 32'd3);
        wait_idle(n);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: hidden registers read zero and ignore writes
        rd(8'h00, d);            chk("R2 hidden control reads 0", d, 0);
        wr(8'h0C, 32'h55);
        wr(8'h48, 32'h1000_0000);
        rd(8'h48, d);            chk("R2 visibility bit", d, 32'h1000_0000);
        rd(8'h0C, d);            chk("R2 write while hidden ignored", d, 0);

        // R1: reset values
        rd(8'h00, d);            chk("R1 control idle", d, 32'h0004_0000);
        rd(8'h1C, d);            chk("R1 pulse time reset", d, 32'd2500);
        rd(8'h34, d);            chk("R1 power-good reset", d, 0);
        rd(8'h2C, d);            chk("R1 lock reset", d, 0);

        // R5: program without power-good is rejected
        wr(8'h04, 32'd4);
        wr(8'h0C, 32'hA5A5_0000);
        wr(8'h00, 32'd2);
        rd(8'h00, d);            chk("R5 reject sets error, stays idle", d, 32'h0004_0100);

        // R4: program timed by pulse register
        wr(8'h34, 32'd1);
        wr(8'h1C, 32'd5);
        wr(8'h00, 32'd2);
        wait_idle(n);            chk("R4 program busy cycles", 64'(n), 5);
        rd(8'h00, d);            chk("R5 accepted command clears error", d, 32'h0004_0000);

        // R7 / R3: read returns sensed view only
        do_read(4, n, d);        chk("R7 burn hidden before sense", d, 0);
                                 chk("R3 read busy cycles", 64'(n), 4);
        do_sense(n);             chk("R3 sense busy cycles", 64'(n), 4);
        do_read(4, n, d);        chk("R7 burn visible after sense", d, 32'hA5A5_0000);

        // R4: OR-only accumulation
        wr(8'h0C, 32'h0000_00FF);
        wr(8'h00, 32'd2);
        wait_idle(n);
        do_sense(n);
        do_read(4, n, d);        chk("R4 bits accumulate", d, 32'hA5A5_00FF);

        // R8: mirror word independent
        do_read(5, n, d);        chk("R8 partner untouched", d, 0);
        wr(8'h00, 32'd2);
        wait_idle(n);
        do_sense(n);
        do_read(5, n, d);        chk("R8 mirror programmed", d, 32'h0000_00FF);
        do_read(4, n, d);        chk("R8 primary unchanged", d, 32'hA5A5_00FF);

        // R10: command while busy ignored
        wr(8'h04, 32'd6);
        wr(8'h0C, 32'h0000_1234);
        wr(8'h00, 32'd2);
        wr(8'h00, 32'd3);
        wait_idle(n);
        do_read(6, n, d);        chk("R10 sense during busy ignored", d, 0);
        do_sense(n);
        do_read(6, n, d);        chk("R10 program completed", d, 32'h0000_1234);

        // R6: sticky lock
        wr(8'h2C, 32'd1);
        wr(8'h2C, 32'd0);
        rd(8'h2C, d);            chk("R6 lock not cleared by 0", d, 1);
        wr(8'h04, 32'd7);
        wr(8'h0C, 32'h0000_F0F0);
        wr(8'h00, 32'd2);
        rd(8'h00, d);            chk("R5 R6 locked program rejected", d, 32'h0004_0100);
        do_sense(n);
        do_read(7, n, d);        chk("R6 array unchanged under lock", d, 0);

        // R9: load stream
        wr(8'h20, 32'd1);
        n = 0;
        forever begin
            @(negedge clk);
            if (opt_valid) n++;
            else break;
        end
                                 chk("R9 load word count", 64'(n), 64);
        rd(8'h00, d);            chk("R9 done flag", d, 32'h4004_0000);

        // R2: hide again
        wr(8'h48, 32'd0);
        rd(8'h2C, d);            chk("R2 rehidden reads 0", d, 0);

        // R6 / R4: reset clears lock; default pulse width
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        wr(8'h48, 32'h1000_0000);
        rd(8'h2C, d);            chk("R6 lock cleared by reset", d, 0);
        wr(8'h34, 32'd1);
        wr(8'h00, 32'd2);
        wait_idle(n);            chk("R4 default pulse cycles", 64'(n), 2500);

        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule